// File: doc/BRIEF.md
# Nibble SECDED Guard with Sticky Error Flag

This block protects 16-bit data words with a single-error-correcting, double-error-detecting code. Each word is treated as four independent 4-bit chunks, and every chunk gets its own 8-bit codeword. The write stream takes a data word and hands out the 32-bit protected code word. The read stream takes a 32-bit code word and returns the repaired data word together with per-word flags for corrected and uncorrectable errors. The storage that holds the code words sits outside the block.

A 16-bit control and status word sets the behaviour. It turns protection on or off, gates an error output pin, and picks which class of event arms that pin. It also holds two sticky history flags. A single self-clearing command bit wipes both history flags and the pin together. The pin is sticky: once set, it stays high until that command or a reset clears it.

Both data interfaces are valid/ready streams. The write stream is combinational: `wr_in_ready` mirrors `wr_out_ready`, and `wr_out_valid` mirrors `wr_in_valid`. The read stream has one register stage. It accepts a word when `rd_in_valid && rd_in_ready`. `rd_in_ready` is high whenever the stage is empty or its content is being taken this cycle. While `rd_out_valid` is high and `rd_out_ready` is low, the output word and its flags hold steady. The register port and the error pin are plain signals.

Top module: `nibble_ecc_guard`

## Requirements
- R1: Chunk i of the data (bits 4i+3:4i) is encoded into code bits 8i+7:8i. The layout inside a chunk codeword is: bit0 = overall parity of bits 7:1, bit1 = d0^d1^d3, bit2 = d0^d2^d3, bit3 = d0, bit4 = d1^d2^d3, bit5 = d1, bit6 = d2, bit7 = d3. For example, nibble 0x1 encodes to 0x0F and nibble 0xF encodes to 0xFF. The write stream is combinational, and `wr_in_ready` equals `wr_out_ready`.
- R2: With protection on, a single flipped bit in a chunk codeword is corrected in `rd_out_data`, and `rd_out_corr` is set for that word.
- R3: With protection on, two flipped bits in a chunk codeword set `rd_out_dbl`. The data of that chunk is not guaranteed.
- R4: Control bit 15 enables protection and resets to 1. While it is 0, each chunk returns its raw data bits {bit7, bit6, bit5, bit3} unchanged, both flags stay 0, and neither history nor the pin records anything.
- R5: Control bit 14 enables the pin and resets to 1. `err_pin` is high only while bits 15 and 14 are both 1. Clearing either bit hides a pending flag without losing it. Events that occur while the pin is disabled do not arm it.
- R6: Control bits 13:12 select which events arm the pin: 00 = corrections only, 01 = double detections only, 10 = either (the reset value), 11 = never.
- R7: Bit 11 is a sticky record of any correction and bit 10 is a sticky record of any double detection. Writes to these two bits have no effect.
- R8: Writing 1 to bit 9 clears bits 11 and 10 and `err_pin` at that edge. Bit 9 always reads 0. An event accepted in the same cycle as the clear is still recorded.
- R9: `err_pin` rises at the same clock edge that places the failing word on `rd_out_data`, and it stays high until it is cleared or the block is reset.
- R10: Bits 8:0 read as 0. The control word reads 0xE000 after reset.
- R11: The read stream has one register stage with `rd_in_ready = !rd_out_valid || rd_out_ready`. A stalled output holds its data and flags stable.
- R12: The four chunks are decoded independently, and the per-word flags are the OR of the per-chunk results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_in_valid | input | 1 | Data word offered for encoding |
| wr_in_ready | output | 1 | Encoder can take the word |
| wr_in_data | input | 16 | Data word to protect |
| wr_out_valid | output | 1 | Code word available |
| wr_out_ready | input | 1 | Downstream takes the code word |
| wr_out_code | output | 32 | Protected code word |
| rd_in_valid | input | 1 | Code word offered for decoding |
| rd_in_ready | output | 1 | Read stage can take the word |
| rd_in_code | input | 32 | Stored code word |
| rd_out_valid | output | 1 | Decoded word available |
| rd_out_ready | input | 1 | Consumer takes the decoded word |
| rd_out_data | output | 16 | Repaired (or raw) data word |
| rd_out_corr | output | 1 | At least one chunk was corrected |
| rd_out_dbl | output | 1 | At least one chunk had a double error |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 16 | Value to write to the control word |
| reg_rd_data | output | 16 | Current control and status word |
| err_pin | output | 1 | Sticky error indicator |

## Verification
Encoded code words are due in the same cycle the data is driven, so they are sampled a fraction of a cycle after the inputs settle. A decoded word, its flags, the history bits and the pin are all due one edge after the read handshake. A control write takes effect on `reg_rd_data` and `err_pin` one edge after its strobe. The bench drives on the falling edge, waits for exactly one rising edge, and samples on the following falling edge. The stalled-output test holds `rd_out_ready` low over two extra edges and checks that nothing moves.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;
  localparam int NIB_W = 4;
  localparam int CW_W  = 8;

  typedef enum logic [1:0] {
    SEL_CORR = 2'b00,
    SEL_DET  = 2'b01,
    SEL_ANY  = 2'b10,
    SEL_NONE = 2'b11
  } err_sel_e;

  typedef struct packed {
    logic     ecc_en;
    logic     pin_en;
    err_sel_e sel;
  } ecc_cfg_t;
endpackage

// File: rtl/ecc_nib_enc.sv
module ecc_nib_enc
  import ecc_guard_pkg::*;
(
  input  logic [NIB_W-1:0] d,
  output logic [CW_W-1:0]  c
);
  logic [7:1] body;

  always_comb begin
    body[1] = d[0] ^ d[1] ^ d[3];
    body[2] = d[0] ^ d[2] ^ d[3];
    body[3] = d[0];
    body[4] = d[1] ^ d[2] ^ d[3];
    body[5] = d[1];
    body[6] = d[2];
    body[7] = d[3];
    c       = {body, ^body};
  end
endmodule

// File: rtl/ecc_nib_dec.sv
module ecc_nib_dec
  import ecc_guard_pkg::*;
(
  input  logic [CW_W-1:0]  c,
  output logic [NIB_W-1:0] d_fix,
  output logic [NIB_W-1:0] d_raw,
  output logic             corr,
  output logic             dbl
);
  logic [2:0]      syn;
  logic            odd;
  logic [CW_W-1:0] fixed;

  always_comb begin
    syn[0] = c[1] ^ c[3] ^ c[5] ^ c[7];
    syn[1] = c[2] ^ c[3] ^ c[6] ^ c[7];
    syn[2] = c[4] ^ c[5] ^ c[6] ^ c[7];
    odd    = ^c;
    corr   = odd;
    dbl    = !odd && (syn != 3'd0);
    fixed  = c;
    if (odd) fixed[syn] = ~c[syn];
    d_fix  = {fixed[7], fixed[6], fixed[5], fixed[3]};
    d_raw  = {c[7], c[6], c[5], c[3]};
  end
endmodule

// File: rtl/ecc_rd_stage.sv
module ecc_rd_stage #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_payload,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_payload
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_payload <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_payload <= in_payload;
    end
  end
endmodule

// File: rtl/ecc_ctrl_reg.sv
module ecc_ctrl_reg
  import ecc_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        ev_corr,
  input  logic        ev_dbl,
  output ecc_cfg_t    cfg,
  output logic [15:0] rd_data,
  output logic        err_pin
);
  logic hist_c, hist_d, err_q, clr, hit;

  assign clr = wr_en && wr_data[9];

  always_comb begin
    case (cfg.sel)
      SEL_CORR: hit = ev_corr;
      SEL_DET:  hit = ev_dbl;
      SEL_ANY:  hit = ev_corr || ev_dbl;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '{ecc_en: 1'b1, pin_en: 1'b1, sel: SEL_ANY};
      hist_c <= 1'b0;
      hist_d <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        cfg.ecc_en <= wr_data[15];
        cfg.pin_en <= wr_data[14];
        cfg.sel    <= err_sel_e'(wr_data[13:12]);
      end
      hist_c <= (hist_c && !clr) || ev_corr;
      hist_d <= (hist_d && !clr) || ev_dbl;
      err_q  <= (err_q && !clr) || (cfg.ecc_en && cfg.pin_en && hit);
    end
  end

  assign err_pin = err_q && cfg.ecc_en && cfg.pin_en;
  assign rd_data = {cfg.ecc_en, cfg.pin_en, cfg.sel, hist_c, hist_d, 10'd0};
endmodule

// File: rtl/nibble_ecc_guard.sv
module nibble_ecc_guard
  import ecc_guard_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_in_valid,
  output logic                         wr_in_ready,
  input  logic [DATA_W-1:0]            wr_in_data,
  output logic                         wr_out_valid,
  input  logic                         wr_out_ready,
  output logic [DATA_W/NIB_W*CW_W-1:0] wr_out_code,
  input  logic                         rd_in_valid,
  output logic                         rd_in_ready,
  input  logic [DATA_W/NIB_W*CW_W-1:0] rd_in_code,
  output logic                         rd_out_valid,
  input  logic                         rd_out_ready,
  output logic [DATA_W-1:0]            rd_out_data,
  output logic                         rd_out_corr,
  output logic                         rd_out_dbl,
  input  logic                         reg_wr_en,
  input  logic [15:0]                  reg_wr_data,
  output logic [15:0]                  reg_rd_data,
  output logic                         err_pin
);
  localparam int CHUNKS = DATA_W / NIB_W;
  localparam int PAY_W  = DATA_W + 2;

  ecc_cfg_t            cfg;
  logic [DATA_W-1:0]   fix_w, raw_w, word_data;
  logic [CHUNKS-1:0]   corr_v, dbl_v;
  logic                word_corr, word_dbl, accept;
  logic [PAY_W-1:0]    pay_in, pay_out;

  assign wr_in_ready  = wr_out_ready;
  assign wr_out_valid = wr_in_valid;

  for (genvar i = 0; i < CHUNKS; i++) begin : g_chunk
    ecc_nib_enc u_enc (
      .d (wr_in_data[i*NIB_W +: NIB_W]),
      .c (wr_out_code[i*CW_W +: CW_W])
    );
    ecc_nib_dec u_dec (
      .c     (rd_in_code[i*CW_W +: CW_W]),
      .d_fix (fix_w[i*NIB_W +: NIB_W]),
      .d_raw (raw_w[i*NIB_W +: NIB_W]),
      .corr  (corr_v[i]),
      .dbl   (dbl_v[i])
    );
  end

  assign word_data = cfg.ecc_en ? fix_w : raw_w;
  assign word_corr = cfg.ecc_en && (|corr_v);
  assign word_dbl  = cfg.ecc_en && (|dbl_v);
  assign accept    = rd_in_valid && rd_in_ready;
  assign pay_in    = {word_dbl, word_corr, word_data};

  ecc_rd_stage #(.W(PAY_W)) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (rd_in_valid),
    .in_ready    (rd_in_ready),
    .in_payload  (pay_in),
    .out_valid   (rd_out_valid),
    .out_ready   (rd_out_ready),
    .out_payload (pay_out)
  );

  assign {rd_out_dbl, rd_out_corr, rd_out_data} = pay_out;

  ecc_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .ev_corr (accept && word_corr),
    .ev_dbl  (accept && word_dbl),
    .cfg     (cfg),
    .rd_data (reg_rd_data),
    .err_pin (err_pin)
  );
endmodule

// File: rtl/nibble_ecc_guard_checker.sv
module nibble_ecc_guard_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_in_valid,
  input logic        rd_in_ready,
  input logic        rd_out_valid,
  input logic        rd_out_ready,
  input logic [15:0] rd_out_data,
  input logic        rd_out_corr,
  input logic        rd_out_dbl,
  input logic        reg_wr_en,
  input logic [15:0] reg_wr_data,
  input logic [15:0] reg_rd_data,
  input logic        err_pin
);
  p_pin_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pin |-> (reg_rd_data[15] && reg_rd_data[14]));

  p_pin_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pin && !reg_wr_en) |=> err_pin);

  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[9:0] == 10'd0);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_data[9] && !rd_in_valid) |=>
      (reg_rd_data[11:10] == 2'b00 && !err_pin));

  p_off_no_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rd_data[15] && rd_in_valid && rd_in_ready) |=> (!rd_out_corr && !rd_out_dbl));

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out_valid && !rd_out_ready) |=>
      (rd_out_valid && $stable(rd_out_data) && $stable(rd_out_corr) && $stable(rd_out_dbl)));

  p_ready_rule_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out_valid && !rd_out_ready) |-> !rd_in_ready);
endmodule

bind nibble_ecc_guard nibble_ecc_guard_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_in_valid  (rd_in_valid),
  .rd_in_ready  (rd_in_ready),
  .rd_out_valid (rd_out_valid),
  .rd_out_ready (rd_out_ready),
  .rd_out_data  (rd_out_data),
  .rd_out_corr  (rd_out_corr),
  .rd_out_dbl   (rd_out_dbl),
  .reg_wr_en    (reg_wr_en),
  .reg_wr_data  (reg_wr_data),
  .reg_rd_data  (reg_rd_data),
  .err_pin      (err_pin)
);

// File: tb/nibble_ecc_guard_bench.sv
`timescale 1ns/1ps
module nibble_ecc_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_in_valid = 1'b0, wr_out_ready = 1'b1;
  logic        wr_in_ready, wr_out_valid;
  logic [15:0] wr_in_data = '0;
  logic [31:0] wr_out_code;
  logic        rd_in_valid = 1'b0, rd_out_ready = 1'b1;
  logic        rd_in_ready, rd_out_valid, rd_out_corr, rd_out_dbl;
  logic [31:0] rd_in_code = '0;
  logic [15:0] rd_out_data;
  logic        reg_wr_en = 1'b0;
  logic [15:0] reg_wr_data = '0;
  logic [15:0] reg_rd_data;
  logic        err_pin;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  nibble_ecc_guard u_nibble_ecc_guard (
    .clk(clk), .rst_n(rst_n),
    .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready), .wr_in_data(wr_in_data),
    .wr_out_valid(wr_out_valid), .wr_out_ready(wr_out_ready), .wr_out_code(wr_out_code),
    .rd_in_valid(rd_in_valid), .rd_in_ready(rd_in_ready), .rd_in_code(rd_in_code),
    .rd_out_valid(rd_out_valid), .rd_out_ready(rd_out_ready), .rd_out_data(rd_out_data),
    .rd_out_corr(rd_out_corr), .rd_out_dbl(rd_out_dbl),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .err_pin(err_pin)
  );

  // {data[15:0], flip mask[31:0]}
  localparam logic [47:0] VEC [8] = '{
    {16'h1234, 32'h0000_0000},
    {16'hA5C3, 32'h0000_0008},
    {16'hFFFF, 32'h8000_0000},
    {16'h0F0F, 32'h0100_0100},
    {16'h5A5A, 32'h0000_0003},
    {16'h9876, 32'h0030_0001},
    {16'h0000, 32'h0000_0001},
    {16'hBEEF, 32'h00C0_0000}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] raw_of(input logic [31:0] c);
    logic [15:0] r;
    for (int i = 0; i < 4; i++) r[4*i +: 4] = {c[8*i+7], c[8*i+6], c[8*i+5], c[8*i+3]};
    return r;
  endfunction

  task automatic get_code(input logic [15:0] d, output logic [31:0] code);
    @(negedge clk);
    wr_in_data  = d;
    wr_in_valid = 1'b1;
    #1 code = wr_out_code;
    wr_in_valid = 1'b0;
  endtask

  task automatic rd_send(input logic [31:0] code);
    @(negedge clk);
    rd_in_valid = 1'b1;
    rd_in_code  = code;
    @(posedge clk);
    @(negedge clk);
    rd_in_valid = 1'b0;
  endtask

  task automatic reg_write(input logic [15:0] v);
    @(negedge clk);
    reg_wr_en   = 1'b1;
    reg_wr_data = v;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] code, sgl, dbl, ca, cb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R10, R4, R5, R6)
    chk(reg_rd_data == 16'hE000, "R10 reset word", {16'd0, reg_rd_data}, 32'hE000);
    chk(!err_pin && !rd_out_valid && rd_in_ready, "R11 reset outputs",
        {29'd0, err_pin, rd_out_valid, rd_in_ready}, 32'h1);

    // encoder layout and stream pass-through (R1)
    get_code(16'h1111, code);
    chk(code == 32'h0F0F_0F0F, "R1 encode 0x1", code, 32'h0F0F_0F0F);
    get_code(16'hFFFF, code);
    chk(code == 32'hFFFF_FFFF, "R1 encode 0xF", code, 32'hFFFF_FFFF);
    @(negedge clk);
    wr_out_ready = 1'b0; wr_in_valid = 1'b1;
    #1 chk(!wr_in_ready && wr_out_valid, "R1 write stream ready", {30'd0, wr_in_ready, wr_out_valid}, 32'h1);
    wr_out_ready = 1'b1; wr_in_valid = 1'b0;

    // table walk: R2 R3 R12
    for (int v = 0; v < 8; v++) begin
      logic [15:0] d, cm;
      logic [31:0] m;
      logic ec, ed;
      d = VEC[v][47:32]; m = VEC[v][31:0];
      ec = 1'b0; ed = 1'b0; cm = '0;
      for (int k = 0; k < 4; k++) begin
        int n;
        n = $countones(m[8*k +: 8]);
        if (n == 1) ec = 1'b1;
        if (n == 2) ed = 1'b1;
        if (n < 2)  cm[4*k +: 4] = 4'hF;
      end
      get_code(d, code);
      rd_send(code ^ m);
      chk(rd_out_valid, "R11 output valid", {31'd0, rd_out_valid}, 32'h1);
      chk((rd_out_data & cm) == (d & cm), "R2 R12 corrected data", {16'd0, rd_out_data & cm}, {16'd0, d & cm});
      chk(rd_out_corr == ec, "R2 R12 corr flag", {31'd0, rd_out_corr}, {31'd0, ec});
      chk(rd_out_dbl == ed, "R3 R12 dbl flag", {31'd0, rd_out_dbl}, {31'd0, ed});
    end
    chk(err_pin, "R9 pin set after events", {31'd0, err_pin}, 32'h1);
    chk(reg_rd_data[11:10] == 2'b11, "R7 history", {30'd0, reg_rd_data[11:10]}, 32'h3);

    // clear (R8) and read-only history (R7)
    reg_write(16'hE200);
    chk(reg_rd_data == 16'hE000 && !err_pin, "R8 clear", {15'd0, err_pin, reg_rd_data}, 32'hE000);
    reg_write(16'hEC00);
    chk(reg_rd_data == 16'hE000, "R7 history write ignored", {16'd0, reg_rd_data}, 32'hE000);

    get_code(16'h1234, code);
    sgl = code ^ 32'h0000_0008;
    dbl = code ^ 32'h0000_0030;

    // pin timing (R9)
    rd_send(sgl);
    chk(err_pin && rd_out_corr && rd_out_data == 16'h1234, "R9 pin with data",
        {14'd0, err_pin, rd_out_corr, rd_out_data}, 32'h3_1234);

    // gating (R5)
    reg_write(16'hA000);
    chk(!err_pin, "R5 pin hidden", {31'd0, err_pin}, 32'h0);
    reg_write(16'hE000);
    chk(err_pin, "R5 pin restored", {31'd0, err_pin}, 32'h1);
    reg_write(16'hE200);
    reg_write(16'hA000);
    rd_send(sgl);
    chk(reg_rd_data == 16'hA800 && !err_pin, "R5 disabled event", {15'd0, err_pin, reg_rd_data}, 32'hA800);
    reg_write(16'hE000);
    chk(!err_pin, "R5 not armed while disabled", {31'd0, err_pin}, 32'h0);

    // select codes (R6)
    reg_write(16'hC200);
    rd_send(dbl);
    chk(!err_pin && reg_rd_data == 16'hC400, "R6 sel00 ignores dbl", {15'd0, err_pin, reg_rd_data}, 32'hC400);
    rd_send(sgl);
    chk(err_pin, "R6 sel00 corr arms", {31'd0, err_pin}, 32'h1);
    reg_write(16'hD200);
    rd_send(sgl);
    chk(!err_pin, "R6 sel01 ignores corr", {31'd0, err_pin}, 32'h0);
    rd_send(dbl);
    chk(err_pin, "R6 sel01 dbl arms", {31'd0, err_pin}, 32'h1);
    reg_write(16'hF200);
    rd_send(sgl);
    rd_send(dbl);
    chk(!err_pin && reg_rd_data == 16'hFC00, "R6 sel11 never", {15'd0, err_pin, reg_rd_data}, 32'hFC00);

    // protection off (R4)
    reg_write(16'h6200);
    rd_send(sgl);
    chk(rd_out_data == raw_of(sgl) && rd_out_data == 16'h1235, "R4 raw pass",
        {16'd0, rd_out_data}, {16'd0, raw_of(sgl)});
    chk(!rd_out_corr && !rd_out_dbl && reg_rd_data == 16'h6000 && !err_pin, "R4 nothing recorded",
        {13'd0, rd_out_corr, rd_out_dbl, err_pin, reg_rd_data}, 32'h6000);
    reg_write(16'hE000);

    // back-pressure (R11)
    get_code(16'hCAFE, ca);
    get_code(16'h0BAD, cb);
    @(negedge clk);
    rd_out_ready = 1'b0; rd_in_valid = 1'b1; rd_in_code = ca;
    @(posedge clk);
    @(negedge clk);
    rd_in_code = cb;
    chk(!rd_in_ready && rd_out_valid && rd_out_data == 16'hCAFE, "R11 stall entry",
        {14'd0, rd_in_ready, rd_out_valid, rd_out_data}, 32'h1_CAFE);
    @(posedge clk);
    @(negedge clk);
    chk(rd_out_data == 16'hCAFE && rd_out_valid, "R11 stall hold", {15'd0, rd_out_valid, rd_out_data}, 32'h1_CAFE);
    rd_out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_in_valid = 1'b0;
    chk(rd_out_data == 16'h0BAD && rd_out_valid, "R11 release", {15'd0, rd_out_valid, rd_out_data}, 32'h1_0BAD);
    @(posedge clk);
    @(negedge clk);
    chk(!rd_out_valid, "R11 drain", {31'd0, rd_out_valid}, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule